// File: doc/BRIEF.md
# Boot Vector ROM Overlay Sequencer

After reset, a 68000-family processor with a byte-wide data bus reads its initial stack pointer and program counter from the bottom of the address space. In normal operation, RAM must sit there instead. This block handles the switch between the two. It holds an overlay flag high from reset, which maps the ROM onto address zero. It counts bus cycles by watching falling edges of the active-low address strobe. The eighth cycle reads the last byte of the two 4-byte vectors. When that cycle completes, the flag drops and address zero decodes to RAM until the next reset. Software needs no register write to leave overlay mode.

The block also contains a small chip-select decoder that uses the flag. The ROM is always visible in its own window at 0x3E0000–0x3E7FFF. An I/O hole at 0x3DD000–0x3DFFFF selects neither memory. All other addresses select RAM, except while the overlay is active: then any address below the ROM size selects the ROM. The strobe is synchronised to the system clock before its edges are detected. Reset is synchronous and active high.

Top module: `boot_overlay_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `overlay` is 1.
- R2: While `overlay` is 1, a strobed access (as_n = 0) to any address below 0x008000 gives rom_sel = 1 and ram_sel = 0.
- R3: A strobe low period counts as exactly one bus access, however many clock cycles it lasts.
- R4: `overlay` stays 1 through the first seven accesses and through the whole eighth access. It drops to 0 within five clock cycles after the strobe rises at the end of the eighth access.
- R5: Once `overlay` is 0, a strobed access to address 0x000000 gives ram_sel = 1 and rom_sel = 0.
- R6: Once `overlay` is 0, it stays 0 for any number of further accesses until `rst` is asserted.
- R7: A strobed access inside 0x3E0000–0x3E7FFF always gives rom_sel = 1. `rom_offset` equals address bits 14:0 on every ROM selection.
- R8: A strobed access inside 0x3DD000–0x3DFFFF gives rom_sel = 0 and ram_sel = 0.
- R9: A strobed access inside 0x3E8000–0x3FFFFF, or below 0x3DD000 outside the overlay case of R2, gives ram_sel = 1 and rom_sel = 0.
- R10: While as_n = 1, rom_sel and ram_sel are both 0, and the two are never 1 together.
- R11: Asserting `rst` partway through the boot sequence sets `overlay` to 1 and restarts the count, so eight fresh accesses are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | CPU address strobe, active low, asynchronous to clk |
| addr | input | 22 | CPU byte address |
| overlay | output | 1 | 1 while the ROM is mapped at address zero |
| rom_sel | output | 1 | ROM chip select, active high |
| ram_sel | output | 1 | RAM chip select, active high |
| rom_offset | output | 15 | Byte offset into the ROM |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a two-stage synchroniser and an eight-access boot window. These values put every decode boundary within reach of directed accesses at the edge addresses. They also make the release point exact: the seventh access leaves the flag set, and the eighth clears it only after its strobe rises. Randomised strobe lengths show that long low periods count once. Two resets bracket a partial sequence to show that the count restarts.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

    typedef enum logic [1:0] {
        REGION_RAM = 2'd0,
        REGION_IO  = 2'd1,
        REGION_ROM = 2'd2
    } region_e;

    typedef struct packed {
        logic rom;
        logic ram;
    } chip_sel_t;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi_excl);
        return (a >= lo) && (a < hi_excl);
    endfunction

endpackage

// File: rtl/ovl_strobe_sync.sv
module ovl_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall_pulse,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= strobe_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain[STAGES-1];
    end

    assign fall_pulse = last_q & ~chain[STAGES-1];
    assign rise_pulse = ~last_q & chain[STAGES-1];
endmodule

// File: rtl/ovl_access_counter.sv
module ovl_access_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_pulse,
    input  logic rise_pulse,
    output logic overlay
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] count_q;
    logic          done_q;

    // Saturating count of strobe falls since reset
    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (fall_pulse && count_q != LIMIT_C)
            count_q <= count_q + 1'b1;
    end

    // Release only once the last counted access has ended
    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (rise_pulse && count_q == LIMIT_C)
            done_q <= 1'b1;
    end

    assign overlay = ~done_q;
endmodule

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode
    import boot_ovl_pkg::*;
#(
    parameter int          ADDR_W    = 22,
    parameter int          ROM_AW    = 15,
    parameter logic [31:0] ROM_BASE  = 32'h003E_0000,
    parameter logic [31:0] IO_BASE   = 32'h003D_D000
) (
    input  logic              strobe_n,
    input  logic              overlay,
    input  logic [ADDR_W-1:0] addr,
    output chip_sel_t         sel,
    output logic [ROM_AW-1:0] rom_offset
);
    localparam logic [31:0] ROM_BYTES = 32'(1) << ROM_AW;
    localparam logic [31:0] ROM_END   = ROM_BASE + ROM_BYTES;

    logic [31:0] a32;
    region_e     region;
    logic        low_shadow;

    assign a32 = 32'(addr);

    always_comb begin
        if (in_window(a32, ROM_BASE, ROM_END))
            region = REGION_ROM;
        else if (in_window(a32, IO_BASE, ROM_BASE))
            region = REGION_IO;
        else
            region = REGION_RAM;
    end

    assign low_shadow = overlay && (a32 < ROM_BYTES);

    always_comb begin
        sel = '0;
        if (!strobe_n) begin
            if (region == REGION_ROM || low_shadow)
                sel.rom = 1'b1;
            else if (region == REGION_RAM)
                sel.ram = 1'b1;
        end
    end

    assign rom_offset = addr[ROM_AW-1:0];
endmodule

// File: rtl/boot_overlay_seq.sv
module boot_overlay_seq
    import boot_ovl_pkg::*;
#(
    parameter int          ADDR_W       = 22,
    parameter int          SYNC_STAGES  = 2,
    parameter int          VECTOR_BYTES = 8,
    parameter int          ROM_AW       = 15,
    parameter logic [31:0] ROM_BASE     = 32'h003E_0000,
    parameter logic [31:0] IO_BASE      = 32'h003D_D000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              overlay,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic [ROM_AW-1:0] rom_offset
);
    logic      fall_p;
    logic      rise_p;
    chip_sel_t sel;

    ovl_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (as_n),
        .fall_pulse (fall_p),
        .rise_pulse (rise_p)
    );

    ovl_access_counter #(.LIMIT(VECTOR_BYTES)) u_count (
        .clk        (clk),
        .rst        (rst),
        .fall_pulse (fall_p),
        .rise_pulse (rise_p),
        .overlay    (overlay)
    );

    ovl_addr_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_AW   (ROM_AW),
        .ROM_BASE (ROM_BASE),
        .IO_BASE  (IO_BASE)
    ) u_dec (
        .strobe_n   (as_n),
        .overlay    (overlay),
        .addr       (addr),
        .sel        (sel),
        .rom_offset (rom_offset)
    );

    assign rom_sel = sel.rom;
    assign ram_sel = sel.ram;
endmodule

// File: rtl/boot_overlay_seq_chk.sv
module boot_overlay_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              as_n,
    input logic [ADDR_W-1:0] addr,
    input logic              overlay,
    input logic              rom_sel,
    input logic              ram_sel
);
    AST_OVL_AFTER_RESET: assert property (@(posedge clk) rst |=> overlay); // R1
    AST_OVL_LOW_ROM: assert property (@(posedge clk) disable iff (rst)
        (overlay && !as_n && addr < ADDR_W'(32768)) |-> (rom_sel && !ram_sel)); // R2
    AST_ZERO_TO_RAM: assert property (@(posedge clk) disable iff (rst)
        (!overlay && !as_n && addr == '0) |-> (ram_sel && !rom_sel)); // R5
    AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !overlay |=> !overlay); // R6
    AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!as_n && addr >= ADDR_W'(32'h3E0000) && addr < ADDR_W'(32'h3E8000)) |-> rom_sel); // R7
    AST_IO_HOLE: assert property (@(posedge clk) disable iff (rst)
        (addr >= ADDR_W'(32'h3DD000) && addr < ADDR_W'(32'h3E0000)) |-> (!rom_sel && !ram_sel)); // R8
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (!rom_sel && !ram_sel)); // R10
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && ram_sel)); // R10
endmodule

bind boot_overlay_seq boot_overlay_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .as_n    (as_n),
    .addr    (addr),
    .overlay (overlay),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel)
);

// File: tb/boot_overlay_seq_tb.sv
module boot_overlay_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1;
    logic [21:0] addr = '0;
    logic        overlay;
    logic        rom_sel;
    logic        ram_sel;
    logic [14:0] rom_offset;

    int checks = 0;
    int errors = 0;
    int done_acc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    boot_overlay_seq u_dut (
        .clk(clk), .rst(rst), .as_n(as_n), .addr(addr),
        .overlay(overlay), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .rom_offset(rom_offset)
    );

    // 0 = RAM, 1 = neither, 2 = ROM
    function automatic int exp_target(input logic [21:0] a, input bit ovl);
        if (a >= 22'h3E0000 && a < 22'h3E8000) return 2;
        if (ovl && a < 22'h008000) return 2;
        if (a >= 22'h3DD000 && a < 22'h3E0000) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        as_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 32'(overlay), 32'd1);
        rst = 1'b0;
        done_acc = 0;
        @(negedge clk);
        check("R1", 32'(overlay), 32'd1);
    endtask

    // One bus access: strobe low for lo cycles, then high for 6 cycles
    task automatic access(input logic [21:0] a, input int lo, input string req);
        bit ovl_exp;
        int tgt;
        ovl_exp = (done_acc < 8);
        tgt = exp_target(a, ovl_exp);
        addr = a;
        as_n = 1'b0;
        @(negedge clk);
        check(req, {31'd0, rom_sel}, {31'd0, tgt == 2});
        check(req, {31'd0, ram_sel}, {31'd0, tgt == 0});
        if (tgt == 2) check("R7", 32'(rom_offset), 32'(a[14:0]));
        for (int i = 1; i < lo; i++) @(negedge clk);
        check(req, 32'(overlay), 32'(ovl_exp));
        as_n = 1'b1;
        @(negedge clk);
        check("R10", {30'd0, rom_sel, ram_sel}, 32'd0);
        repeat (5) @(negedge clk);
        done_acc++;
        check(req, 32'(overlay), 32'(done_acc < 8));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        check("R10", {30'd0, rom_sel, ram_sel}, 32'd0);
        // R2 / R3: long strobe at the reset vector address counts once
        access(22'h000000, 9, "R2");
        access(22'h000001, 1, "R3");
        access(22'h3DD000, 2, "R8");
        access(22'h3E0004, 3, "R7");
        access(22'h007FFF, 1, "R2");
        access(22'h3E8000, 2, "R9");
        access(22'h000006, 4, "R4");
        check("R4", 32'(overlay), 32'd1);
        // eighth access: overlay still set during it, cleared after
        access(22'h000007, 5, "R4");
        check("R4", 32'(overlay), 32'd0);
        access(22'h000000, 2, "R5");
        // directed boundaries after release
        access(22'h3DCFFF, 1, "R9");
        access(22'h3DFFFF, 1, "R8");
        access(22'h3E7FFF, 1, "R7");
        access(22'h3FFFFF, 1, "R9");
        access(22'h007FFF, 1, "R9");
        // random traffic: overlay must stay released
        for (int k = 0; k < 150; k++) begin
            logic [21:0] ra;
            int pick;
            pick = int'($urandom_range(0, 3));
            case (pick)
                0: ra = 22'h3DD000 + 22'($urandom_range(0, 32'h2FFF));
                1: ra = 22'h3E0000 + 22'($urandom_range(0, 32'h7FFF));
                2: ra = 22'($urandom_range(0, 32'h7FFF));
                default: ra = 22'($urandom);
            endcase
            access(ra, int'($urandom_range(1, 4)), "R6");
        end
        check("R6", 32'(overlay), 32'd0);
        // R11: reset midway restarts the count
        do_reset();
        for (int k = 0; k < 5; k++) access(22'(k), 2, "R11");
        do_reset();
        for (int k = 0; k < 7; k++)
            access(22'($urandom_range(0, 32'h3FFFFF)), int'($urandom_range(1, 6)), "R11");
        check("R11", 32'(overlay), 32'd1);
        access(22'h000003, 2, "R11");
        check("R11", 32'(overlay), 32'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule